// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value for an IEEE 1588 clock. A 32-bit phase accumulator runs from the reference clock and adds a programmable addend to itself on every enabled cycle. Each carry out of the accumulator is one nominal tick, and each tick advances the 64-bit counter by a programmable nominal period in nanoseconds. Software sets the addend to ceil(2^32 × nominal_freq / reference_freq), so ticks come at the nominal rate on average. Fine frequency steering is done by rewriting the addend while the counter runs.

A separate 64-bit offset is added to the counter to form the reported time, so software can shift time without touching the counter. The control word, addend, counter and offset sit behind a plain single-cycle register port. The 64-bit values are accessed as two 32-bit halves. Reads are coherent when the low half is read first, and writes are atomic when the high half is written last. The register port is control traffic and has no back-pressure: a write completes in its own cycle, and read data appears one cycle after the request.

Top module: `tod_counter`

## Requirements
- R1: After reset the counter, offset, accumulator, addend and control word are zero. `time_now` is 0, and every mapped register reads 0.
- R2: While the enable bit (control word bit 0) is clear, neither the counter nor the accumulator changes, except through a counter write.
- R3: While enabled, each cycle the accumulator becomes (accumulator + addend) mod 2^32. The counter grows by the period field (control word bits 15:8) on exactly those cycles where that sum carries out of bit 31.
- R4: `time_now` equals (counter + offset) mod 2^64 on every cycle.
- R5: A write to the counter low word (address 2) is only staged and leaves the time unchanged. A write to the counter high word (address 3) loads {high data, staged low} into the counter at that clock edge.
- R6: A read of the counter low word returns the current low half and captures the current high half. A later read of the counter high word (address 3) returns that captured half, even if the counter has since carried into its high half.
- R7: The offset is loaded the same way, low word at address 4 staged and high word at address 5 committing. The offset changes at no other time and never disturbs the counter.
- R8: A new addend takes effect from the cycle after its write (address 1). The accumulator keeps its fractional residue and the counter keeps its value across the change.
- R9: Read data is presented on `bus_rdata` on the cycle after `bus_rd`. Address map: 0 control, 1 addend, 2 counter low, 3 counter high (snapshot), 4 offset low, 5 offset high. Addresses 6 and 7 read as 0, and writes to them have no effect.
- R10: A counter load that coincides with a tick takes the written value exactly; the tick of that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| time_now | output | 64 | Reported time, counter plus offset |

## Verification
The assertions watch, on every cycle, four kinds of behaviour:
- The hold of counter and accumulator while disabled.
- The counter step being either zero or exactly one period.
- The accumulator's modular update from the addend in use.
- The high-word commit and the offset's stability between commits.

Some behaviour needs a sequence of register accesses and only the bench scenarios can show it:
- The coherence of a split counter read across a low-to-high carry.
- The staging of low-word writes.
- The dropped tick on a coinciding load.
- The inertness of the unmapped addresses.

The bench's behavioural model is compared with the reported time and the read data on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_ADDEND = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_CNT_HI = 3'd3,
    RA_OFF_LO = 3'd4,
    RA_OFF_HI = 3'd5
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PER_LSB = 8;
endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc_q,
  output logic             tick
);
  logic [ACC_W:0] sum;

  assign sum  = {1'b0, acc_q} + {1'b0, addend};
  assign tick = en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
  parameter int TIME_W = 64,
  parameter int PER_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PER_W-1:0]  period,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] cnt_q
);
  logic [TIME_W-1:0] step;

  assign step = {{(TIME_W-PER_W){1'b0}}, period};

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + step;
  end
endmodule

// File: rtl/tod_regbank.sv
module tod_regbank
  import tod_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [2*BUS_W-1:0]  cnt_q,
  output logic                en,
  output logic [PER_W-1:0]    period,
  output logic [ACC_W-1:0]    addend,
  output logic [2*BUS_W-1:0]  off_q,
  output logic                cnt_load,
  output logic [2*BUS_W-1:0]  cnt_load_val
);
  logic [BUS_W-1:0] cnt_stage, off_stage, cnt_hi_snap, ctrl_word, rd_mux;
  reg_addr_e        ra;

  assign ra           = reg_addr_e'(bus_addr);
  assign cnt_load     = bus_wr && (ra == RA_CNT_HI);
  assign cnt_load_val = {bus_wdata, cnt_stage};

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT] = en;
    ctrl_word[CTRL_PER_LSB +: PER_W] = period;
  end

  always_comb begin
    case (ra)
      RA_CTRL:   rd_mux = ctrl_word;
      RA_ADDEND: rd_mux = BUS_W'(addend);
      RA_CNT_LO: rd_mux = cnt_q[BUS_W-1:0];
      RA_CNT_HI: rd_mux = cnt_hi_snap;
      RA_OFF_LO: rd_mux = off_q[BUS_W-1:0];
      RA_OFF_HI: rd_mux = off_q[2*BUS_W-1:BUS_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      period    <= '0;
      addend    <= '0;
      cnt_stage <= '0;
      off_stage <= '0;
      off_q     <= '0;
    end else if (bus_wr) begin
      case (ra)
        RA_CTRL: begin
          en     <= bus_wdata[CTRL_EN_BIT];
          period <= bus_wdata[CTRL_PER_LSB +: PER_W];
        end
        RA_ADDEND: addend    <= bus_wdata[ACC_W-1:0];
        RA_CNT_LO: cnt_stage <= bus_wdata;
        RA_OFF_LO: off_stage <= bus_wdata;
        RA_OFF_HI: off_q     <= {bus_wdata, off_stage};
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      cnt_hi_snap <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
      if (ra == RA_CNT_LO) cnt_hi_snap <= cnt_q[2*BUS_W-1:BUS_W];
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PER_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic [2*BUS_W-1:0]  time_now
);
  localparam int TIME_W = 2 * BUS_W;

  logic              ctl_en, acc_tick, cnt_load;
  logic [PER_W-1:0]  ctl_period;
  logic [ACC_W-1:0]  ctl_addend, acc_q;
  logic [TIME_W-1:0] off_q, cnt_q, cnt_load_val;

  tod_regbank #(.ACC_W(ACC_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_q(cnt_q), .en(ctl_en), .period(ctl_period), .addend(ctl_addend),
    .off_q(off_q), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val)
  );

  tod_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .addend(ctl_addend),
    .acc_q(acc_q), .tick(acc_tick)
  );

  tod_ns_counter #(.TIME_W(TIME_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(acc_tick), .period(ctl_period),
    .load(cnt_load), .load_val(cnt_load_val), .cnt_q(cnt_q)
  );

  assign time_now = cnt_q + off_q;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PER_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic               en,
  input logic [PER_W-1:0]   period,
  input logic [ACC_W-1:0]   addend,
  input logic [ACC_W-1:0]   acc_q,
  input logic [2*BUS_W-1:0] cnt_q,
  input logic [2*BUS_W-1:0] off_q
);
  logic hi_wr, off_hi_wr;
  logic [2*BUS_W-1:0] step;

  assign hi_wr     = bus_wr && (bus_addr == 3'd3);
  assign off_hi_wr = bus_wr && (bus_addr == 3'd5);
  assign step      = {{(2*BUS_W-PER_W){1'b0}}, period};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hi_wr) |=> ($stable(cnt_q) && $stable(acc_q)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hi_wr) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + $past(step))));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (cnt_q[2*BUS_W-1:BUS_W] == $past(bus_wdata)));

  p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !off_hi_wr |=> $stable(off_q));

  p_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (acc_q == $past(acc_q) + $past(addend)));
endmodule

bind tod_counter tod_counter_chk #(.ACC_W(ACC_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en(ctl_en), .period(ctl_period), .addend(ctl_addend),
  .acc_q(acc_q), .cnt_q(cnt_q), .off_q(off_q)
);

// File: tb/tb_tod_counter.sv
module tb_tod_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] time_now;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  tod_counter dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_now(time_now));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [63:0] m_cnt, m_off, m_acc, m_add, m_sum, m_next;
  bit [31:0] m_cstage, m_ostage, m_snap, m_rdata;
  bit [7:0]  m_per;
  bit        m_en, m_rd_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_off = 0; m_acc = 0; m_add = 0; m_cstage = 0; m_ostage = 0;
      m_snap = 0; m_rdata = 0; m_per = 0; m_en = 0; m_rd_pend = 0;
    end else begin
      m_sum  = m_acc + m_add;
      m_next = m_cnt;
      if (m_en) begin
        m_acc = m_sum & 64'hFFFF_FFFF;
        if (m_sum[32]) m_next = m_cnt + 64'(m_per);
      end
      m_rd_pend = bus_rd;
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata = {16'd0, m_per, 7'd0, m_en};
          3'd1: m_rdata = m_add[31:0];
          3'd2: begin m_rdata = m_cnt[31:0]; m_snap = m_cnt[63:32]; end
          3'd3: m_rdata = m_snap;
          3'd4: m_rdata = m_off[31:0];
          3'd5: m_rdata = m_off[63:32];
          default: m_rdata = 0;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin m_en = bus_wdata[0]; m_per = bus_wdata[15:8]; end
          3'd1: m_add = 64'(bus_wdata);
          3'd2: m_cstage = bus_wdata;
          3'd3: m_next = {bus_wdata, m_cstage};
          3'd4: m_ostage = bus_wdata;
          3'd5: m_off = {bus_wdata, m_ostage};
          default: ;
        endcase
      end
      m_cnt = m_next;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_cmp++;
      if (time_now !== m_cnt + m_off) begin
        n_bad++;
        $display("FAIL R4 per-cycle time: actual %h expected %h", time_now, m_cnt + m_off);
      end
      if (m_rd_pend) begin
        n_cmp++;
        if (bus_rdata !== m_rdata) begin
          n_bad++;
          $display("FAIL R9 per-cycle read data: actual %h expected %h", bus_rdata, m_rdata);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic [63:0] t0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 time after reset", time_now, 64'd0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register after reset", 64'(d), 64'd0);
    end

    // R2 disabled: period 5, addend half, no enable
    wr(3'd0, 32'h0000_0500);
    wr(3'd1, 32'h8000_0000);
    idle(8);
    chk("R2 hold while disabled", time_now, 64'd0);

    // R3 enabled: one carry every two cycles, step 5
    wr(3'd0, 32'h0000_0501);
    idle(20);
    chk("R3 advancing time", time_now, m_cnt + m_off);
    chk("R3 time moved", 64'(time_now != 0), 64'd1);

    // R8 addend rewrite mid-run
    t0 = time_now;
    wr(3'd1, 32'h4000_0000);
    idle(16);
    chk("R8 after addend change", time_now, m_cnt + m_off);
    rd(3'd1, d);
    chk("R8 addend readback", 64'(d), 64'h4000_0000);

    // R5 staged counter write, disabled
    wr(3'd0, 32'h0000_0500);
    t0 = time_now;
    wr(3'd2, 32'hFFFF_FFF0);
    chk("R5 low write staged only", time_now, t0);
    wr(3'd3, 32'h0000_0003);
    chk("R5 high write commits", time_now, 64'h3_FFFF_FFF0);

    // R6 coherent split read across a carry into the high half
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0000_0501);
    rd(3'd2, d);
    idle(12);
    chk("R6 counter now past carry", 64'(time_now[63:32]), 64'd4);
    rd(3'd3, d);
    chk("R6 high read returns snapshot", 64'(d), 64'd3);

    // R7 / R4 offset
    wr(3'd0, 32'h0000_0500);
    t0 = time_now;
    wr(3'd4, 32'h0000_0100);
    chk("R7 offset low staged only", time_now, t0);
    wr(3'd5, 32'h0000_0001);
    chk("R4 time equals counter plus offset", time_now, t0 + 64'h1_0000_0100);
    rd(3'd5, d);
    chk("R7 offset high readback", 64'(d), 64'd1);

    // R9 unmapped addresses
    t0 = time_now;
    wr(3'd6, 32'hDEAD_BEEF);
    wr(3'd7, 32'h0000_FF01);
    rd(3'd7, d);
    chk("R9 unmapped read zero", 64'(d), 64'd0);
    rd(3'd0, d);
    chk("R9 control unchanged by unmapped write", 64'(d), 64'h0000_0500);
    chk("R9 time unchanged by unmapped write", time_now, t0);

    // R10 load coinciding with a tick while running
    wr(3'd0, 32'h0000_0701);
    idle(3);
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'h0000_0010);
    chk("R10 load wins over tick", time_now, 64'h10_0000_0000 + 64'h1_0000_0100);
    idle(10);
    chk("R3 running after load", time_now, m_cnt + m_off);

    // R2 disable again holds
    wr(3'd0, 32'h0000_0700);
    t0 = time_now;
    idle(10);
    chk("R2 hold after disable", time_now, t0);

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule